// File: doc/BRIEF.md
# Banked ROM Mapper with Nibble RAM

This block sits between a CPU with a 16-bit address bus and a large cartridge ROM. The lower 16 KiB of the CPU space always shows the first 16 KiB page of the ROM. The next 16 KiB window shows whichever page the CPU has selected. The block turns each CPU address into a wide ROM address, and the ROM returns the byte combinationally on `rom_data_i`.

The block also holds a small RAM of 512 four-bit cells. That RAM appears over the whole 8 KiB external-RAM window, repeating every 512 bytes. Two control functions share one write region in the low 16 KiB: RAM enable and page select. Address bit 8 picks which one a write reaches. Reads are combinational. Writes to the control registers and to the RAM take effect at the rising clock edge.

Top module: `rom_mapper`

## Requirements
- R1: After reset is released, the selected page is 1 and the RAM is disabled.
- R2: A read of 0x0000–0x3FFF puts `{0, addr[13:0]}` on `rom_addr_o` and returns `rom_data_i` on `rdata_o`.
- R3: A read of 0x4000–0x7FFF puts `page*0x4000 + addr[13:0]` on `rom_addr_o` and returns `rom_data_i` on `rdata_o`.
- R4: A write to 0x0000–0x3FFF with address bit 8 = 0 enables the RAM when the data is 0x0A, and disables it for any other data value.
- R5: A write to 0x0000–0x3FFF with address bit 8 = 1 selects page = data. Data 0 selects page 1. Data above BANKS-1 selects page BANKS-1.
- R6: Writes outside 0x0000–0x3FFF leave the selected page and the RAM-enable state unchanged.
- R7: While enabled, the RAM holds 512 four-bit cells, indexed by addr[8:0], across all of 0xA000–0xBFFF. A read returns {4'hF, cell}. A write stores data[3:0].
- R8: While disabled, RAM-window reads return 0xFF, and RAM writes do not change any cell.
- R9: Reads of 0x8000–0x9FFF and 0xC000–0xFFFF return 0xFF. `rdata_o` is also 0xFF whenever `rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | CPU write data |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data to the CPU |
| rom_addr_o | output | ROM_AW | Byte address into the ROM |
| rom_data_i | input | 8 | Byte returned by the ROM |

## Verification
The bench writes page 0 and checks that page 1 is selected; a design without the remap would map the fixed page a second time. It also writes 15, 16 and 0xFF as page numbers. A design with an off-by-one clamp, or one that truncates the value, would produce a wrong upper ROM address. The bench reads RAM cells through mirror addresses as high as 0xBE00, to catch a design that decodes only 0xA000–0xA1FF. It toggles the enable with data 0x0B and with a write whose address has bit 8 clear inside the region. It also writes the RAM while it is disabled and then reads back, to show that a design which still latches those writes corrupts the stored nibble.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  typedef enum logic [1:0] {
    RGN_ROM0 = 2'd0,
    RGN_ROMX = 2'd1,
    RGN_RAM  = 2'd2,
    RGN_NONE = 2'd3
  } region_e;

  function automatic region_e decode_region(input logic [15:0] a);
    if (a[15:14] == 2'b00)      return RGN_ROM0;
    else if (a[15:14] == 2'b01) return RGN_ROMX;
    else if (a[15:13] == 3'b101) return RGN_RAM;
    else                         return RGN_NONE;
  endfunction
endpackage

// File: rtl/mapper_ctrl.sv
module mapper_ctrl #(
  parameter int BANKS  = 16,
  parameter int BANK_W = $clog2(BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              sel_bank_i,
  input  logic [7:0]        wdata_i,
  output logic [BANK_W-1:0] bank_o,
  output logic              ram_en_o
);
  localparam logic [7:0] TOP_BANK = 8'(BANKS - 1);

  logic [7:0] bank_d;

  always_comb begin
    if (wdata_i == 8'h00)        bank_d = 8'h01;
    else if (wdata_i > TOP_BANK) bank_d = TOP_BANK;
    else                         bank_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_o   <= BANK_W'(1);
      ram_en_o <= 1'b0;
    end else if (we_i) begin
      if (sel_bank_i) bank_o   <= bank_d[BANK_W-1:0];
      else            ram_en_o <= (wdata_i == 8'h0A);
    end
  end
endmodule

// File: rtl/mapper_ram.sv
module mapper_ram #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 4,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    idx_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/mapper_rdmux.sv
module mapper_rdmux
  import mapper_pkg::*;
(
  input  logic       rd_i,
  input  region_e    rgn_i,
  input  logic [7:0] rom_data_i,
  input  logic       ram_ok_i,
  input  logic [3:0] ram_nib_i,
  output logic [7:0] rdata_o
);
  always_comb begin
    rdata_o = 8'hFF;
    if (rd_i) begin
      unique case (rgn_i)
        RGN_ROM0, RGN_ROMX: rdata_o = rom_data_i;
        RGN_RAM:            rdata_o = ram_ok_i ? {4'hF, ram_nib_i} : 8'hFF;
        default:            rdata_o = 8'hFF;
      endcase
    end
  end
endmodule

// File: rtl/rom_mapper.sv
module rom_mapper
  import mapper_pkg::*;
#(
  parameter int BANKS     = 16,
  parameter bit HAS_RAM   = 1'b1,
  parameter int RAM_DEPTH = 512,
  parameter int BANK_W    = $clog2(BANKS),
  parameter int ROM_AW    = BANK_W + 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [7:0]        rdata_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  input  logic [7:0]        rom_data_i
);
  localparam int RAM_AW = $clog2(RAM_DEPTH);

  region_e           rgn;
  logic [BANK_W-1:0] bank_q;
  logic              ram_en_q;
  logic              ram_ok;
  logic [3:0]        ram_nib;

  assign rgn = decode_region(addr_i);

  mapper_ctrl #(.BANKS(BANKS), .BANK_W(BANK_W)) ctrl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (wr_i && rgn == RGN_ROM0),
    .sel_bank_i (addr_i[8]),
    .wdata_i    (wdata_i),
    .bank_o     (bank_q),
    .ram_en_o   (ram_en_q)
  );

  assign rom_addr_o = {(rgn == RGN_ROMX) ? bank_q : BANK_W'(0), addr_i[13:0]};

  generate
    if (HAS_RAM) begin : g_ram
      assign ram_ok = ram_en_q;
      mapper_ram #(.DEPTH(RAM_DEPTH), .WIDTH(4), .AW(RAM_AW)) ram_i (
        .clk_i   (clk_i),
        .we_i    (wr_i && rgn == RGN_RAM && ram_en_q),
        .idx_i   (addr_i[RAM_AW-1:0]),
        .wdata_i (wdata_i[3:0]),
        .rdata_o (ram_nib)
      );
    end else begin : g_no_ram
      assign ram_ok  = 1'b0;
      assign ram_nib = 4'h0;
    end
  endgenerate

  mapper_rdmux rdmux_i (
    .rd_i       (rd_i),
    .rgn_i      (rgn),
    .rom_data_i (rom_data_i),
    .ram_ok_i   (ram_ok),
    .ram_nib_i  (ram_nib),
    .rdata_o    (rdata_o)
  );
endmodule

// File: rtl/rom_mapper_chk.sv
module rom_mapper_chk #(
  parameter int BANKS  = 16,
  parameter int BANK_W = $clog2(BANKS),
  parameter int ROM_AW = BANK_W + 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [15:0]       addr_i,
  input logic [7:0]        wdata_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [7:0]        rdata_o,
  input logic [ROM_AW-1:0] rom_addr_o,
  input logic [BANK_W-1:0] bank_q,
  input logic              ram_en_q
);
  localparam logic [BANK_W-1:0] TOP = BANK_W'(BANKS - 1);

  // R2
  fixed_page_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:14] == 2'b00) |-> (rom_addr_o[ROM_AW-1:14] == '0));

  // R5
  page_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:14] == 2'b01) |->
      (rom_addr_o[ROM_AW-1:14] != '0 && rom_addr_o[ROM_AW-1:14] <= TOP));

  // R4
  enable_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[15:14] == 2'b00 && !addr_i[8]) |=>
      (ram_en_q == ($past(wdata_i) == 8'h0A)));

  // R6
  outside_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[15:14] != 2'b00) |=> ($stable(bank_q) && $stable(ram_en_q)));

  // R7
  ram_upper_nibble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[15:13] == 3'b101) |-> (rdata_o[7:4] == 4'hF));

  // R8
  ram_off_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[15:13] == 3'b101 && !ram_en_q) |-> (rdata_o == 8'hFF));

  // R9
  unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i || addr_i[15:13] == 3'b100 || addr_i[15:14] == 2'b11) |-> (rdata_o == 8'hFF));
endmodule

bind rom_mapper rom_mapper_chk #(.BANKS(BANKS), .BANK_W(BANK_W), .ROM_AW(ROM_AW)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .rdata_o    (rdata_o),
  .rom_addr_o (rom_addr_o),
  .bank_q     (bank_q),
  .ram_en_q   (ram_en_q)
);

// File: tb/rom_mapper_tb_top.sv
`timescale 1ns/1ps
module rom_mapper_tb_top;
  localparam int BANKS  = 16;
  localparam int ROM_AW = 18;

  // ops: 0 write, 1 expect rdata, 2 expect rom_addr, 3 expect rdata == rom byte at given address
  localparam int NV = 33;
  // {op[3:0], req[3:0], addr[15:0], value[23:0]}
  localparam logic [47:0] VEC [NV] = '{
    {4'd2, 4'd1, 16'h4000, 24'h004000},  // R1 page 1 after reset
    {4'd1, 4'd1, 16'hA000, 24'h0000FF},  // R1 RAM off after reset
    {4'd0, 4'd5, 16'h2100, 24'h000005},  // R5 select page 5
    {4'd2, 4'd3, 16'h4123, 24'h014123},  // R3
    {4'd3, 4'd3, 16'h4123, 24'h014123},  // R3 data path
    {4'd2, 4'd2, 16'h1234, 24'h001234},  // R2
    {4'd3, 4'd2, 16'h3FFF, 24'h003FFF},  // R2 data path
    {4'd0, 4'd5, 16'h2100, 24'h000000},  // R5 page 0 -> 1
    {4'd2, 4'd5, 16'h7FFF, 24'h007FFF},
    {4'd0, 4'd5, 16'h3100, 24'h000040},  // R5 clamp
    {4'd2, 4'd5, 16'h4000, 24'h03C000},
    {4'd0, 4'd4, 16'h0000, 24'h00000A},  // R4 enable
    {4'd0, 4'd7, 16'hA005, 24'h00003C},  // R7 write
    {4'd1, 4'd7, 16'hA005, 24'h0000FC},
    {4'd1, 4'd7, 16'hA205, 24'h0000FC},  // R7 mirror
    {4'd1, 4'd7, 16'hBE05, 24'h0000FC},
    {4'd0, 4'd4, 16'h1E00, 24'h00000B},  // R4 disable
    {4'd1, 4'd8, 16'hA005, 24'h0000FF},  // R8 off read
    {4'd0, 4'd8, 16'hA005, 24'h000007},  // R8 ignored write
    {4'd0, 4'd4, 16'h0000, 24'h00000A},
    {4'd1, 4'd8, 16'hA005, 24'h0000FC},  // R8 cell kept
    {4'd0, 4'd6, 16'h4100, 24'h000003},  // R6 no page change
    {4'd2, 4'd6, 16'h4000, 24'h03C000},
    {4'd0, 4'd6, 16'h8000, 24'h000000},  // R6 no enable change
    {4'd0, 4'd6, 16'hC000, 24'h000000},
    {4'd1, 4'd6, 16'hA005, 24'h0000FC},
    {4'd1, 4'd9, 16'hC000, 24'h0000FF},  // R9
    {4'd1, 4'd9, 16'hFFFF, 24'h0000FF},
    {4'd1, 4'd9, 16'h8000, 24'h0000FF},
    {4'd0, 4'd5, 16'h0100, 24'h000002},  // R5 bit 8 set in low region
    {4'd2, 4'd5, 16'h4000, 24'h008000},
    {4'd3, 4'd3, 16'h4001, 24'h008001},
    {4'd1, 4'd9, 16'h9FFF, 24'h0000FF}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [15:0]       addr_i = '0;
  logic [7:0]        wdata_i = '0;
  logic              rd_i = 1'b0;
  logic              wr_i = 1'b0;
  logic [7:0]        rdata_o;
  logic [ROM_AW-1:0] rom_addr_o;
  logic [7:0]        rom_data_i;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  function automatic logic [7:0] rom_byte(input logic [ROM_AW-1:0] a);
    return a[7:0] ^ a[17:10] ^ 8'h5A;
  endfunction

  assign rom_data_i = rom_byte(rom_addr_o);

  rom_mapper #(.BANKS(BANKS)) dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .rdata_o    (rdata_o),
    .rom_addr_o (rom_addr_o),
    .rom_data_i (rom_data_i)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1; rd_i = 1'b0;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1; wr_i = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  op;
      logic [3:0]  rq;
      logic [15:0] a;
      logic [23:0] v;
      string       tag;
      {op, rq, a, v} = VEC[i];
      tag = $sformatf("R%0d vec %0d", rq, i);
      case (op)
        4'd0: wr(a, v[7:0]);
        4'd1: begin rd(a); check(tag, {16'h0, rdata_o}, v); end
        4'd2: begin rd(a); check(tag, {6'h0, rom_addr_o}, v); end
        default: begin rd(a); check(tag, {16'h0, rdata_o}, {16'h0, rom_byte(v[ROM_AW-1:0])}); end
      endcase
    end

    // R5 boundary page values
    wr(16'h2100, 8'h0F); rd(16'h4000); check("R5 page 15", {6'h0, rom_addr_o}, 24'h03C000);
    wr(16'h2100, 8'h10); rd(16'h4000); check("R5 page 16 clamp", {6'h0, rom_addr_o}, 24'h03C000);
    wr(16'h2100, 8'hFF); rd(16'h4000); check("R5 page 0xFF clamp", {6'h0, rom_addr_o}, 24'h03C000);
    wr(16'h2100, 8'h01); rd(16'h4ABC); check("R3 page 1", {6'h0, rom_addr_o}, 24'h004ABC);

    // R9 read strobe low
    @(negedge clk_i); addr_i = 16'h1000; rd_i = 1'b0; #1;
    check("R9 rd low", {16'h0, rdata_o}, 24'h0000FF);

    // R7 full RAM fill and readback through a mirror window
    wr(16'h0000, 8'h0A);
    for (int k = 0; k < 512; k++) wr(16'hA000 + 16'(k), 8'(k * 7 + 3));
    begin
      int bad = 0;
      for (int k = 0; k < 512; k++) begin
        rd(16'hB600 + 16'(k));
        if (rdata_o !== {4'hF, 4'(k * 7 + 3)}) bad++;
      end
      check("R7 mirror fill mismatches", 24'(bad), 24'h0);
    end

    // R1 reset mid-run
    wr(16'h2100, 8'h06);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    rd(16'h4000); check("R1 page after reset", {6'h0, rom_addr_o}, 24'h004000);
    rd(16'hA010); check("R1 RAM off after reset", {16'h0, rdata_o}, 24'h0000FF);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule